// File: doc/BRIEF.md
# Interrupt Pin Request Tracker

This block holds the per-pin request logic of an interrupt router. Each cycle it takes the raw pin levels and passes them through a two-flop synchronizer. It applies each pin's polarity and decides, from the pin's trigger mode, mask bit and in-service flag, whether the pin needs a delivery. Pins that need a delivery are queued in a service-pending vector. The lowest-numbered queued pin drives a single delivery request, which carries the pin number and the pin's vector and is held until the downstream logic accepts it. Choosing the target of the delivery is done elsewhere.

Edge-mode pins are queued once for each rising effective level. They hold no in-service state, so a level that stays high does not queue them again. Level-mode pins are queued while their effective level is high and their in-service flag is clear. An accepted delivery sets that flag, and it stays set until an end-of-interrupt notice names the pin's vector. One notice clears the flag on every pin that holds that vector, and any of those pins that is still high and unmasked is queued again.

Top module: `irq_pin_tracker`

## Requirements
- R1: A change on `pin_raw` passes through two synchronizer stages. A rising edge that arrives between two clock edges shows up on `dlv_req` just after the third clock edge that follows it.
- R2: The effective level of a pin is `pin_raw ^ cfg_pol`. With `cfg_pol`=1 the pin is active-low.
- R3: An edge-mode pin (`cfg_trig`=0) is queued once for each 0-to-1 change of its effective level. A pending request that is accepted (`dlv_req & dlv_ack`) is removed. Holding the level high afterwards produces no further request.
- R4: A level-mode pin (`cfg_trig`=1) is queued when its effective level is high, its in-service flag is clear, and it is not being accepted in the same cycle. Once its in-service flag is set, no further request is made.
- R5: A masked pin (`cfg_mask`=1) never drives `dlv_req`. Masking a queued pin removes it from the queue by the next clock edge. An edge that occurs while the pin is masked is lost.
- R6: When several pins are queued, `dlv_req` names the lowest-numbered unmasked one. The others stay queued until they are accepted.
- R7: An accepted delivery of a level-mode pin sets that pin's bit in `in_service` at the clock edge of the acceptance. An accepted delivery of an edge-mode pin leaves `in_service` unchanged.
- R8: An end-of-interrupt notice (`eoi_valid`=1) clears, at the next clock edge, every `in_service` bit whose pin's `cfg_vec` field equals `eoi_vec`. If a delivery of the same pin is accepted in the same cycle, the set wins. A level-mode pin that is cleared this way and is still high and unmasked requests again.
- R9: An end-of-interrupt notice leaves the `in_service` bits of pins holding other vectors unchanged.
- R10: After reset, `dlv_req` is 0 and `in_service` is all zeros.
- R11: While `dlv_req` is 1, `dlv_vec` equals the `cfg_vec` field of the pin named by `dlv_pin`. Pin i's field is `cfg_vec[i*VEC_W +: VEC_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPINS | Raw, asynchronous pin levels |
| cfg_pol | input | NPINS | Per-pin polarity, 1 = active-low |
| cfg_trig | input | NPINS | Per-pin trigger mode, 0 = edge, 1 = level |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_vec | input | NPINS*VEC_W | Per-pin vector fields, packed with pin 0 in the lowest bits |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vec | input | VEC_W | Vector named by the notice |
| dlv_ack | input | 1 | Downstream accepts the current request |
| dlv_req | output | 1 | Delivery request valid |
| dlv_pin | output | PIN_W | Pin number of the request |
| dlv_vec | output | VEC_W | Vector of the requesting pin |
| in_service | output | NPINS | Per-pin in-service flags |

## Verification
The bench builds the block with NPINS=5 and VEC_W=4. With five pins, the index is three bits wide and the codes above pin 4 are never used, so a non-power-of-two pin count is covered. With four-bit vectors, two pins can share one vector, so a single notice that clears several pins, and the lowest-first re-service that follows, can be reached quickly. A behavioural reference model is compared with the outputs on every cycle. The comparison runs through directed cases and a long phase in which the pin levels, the configuration, the acceptances and the notices change at random.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  function automatic int pin_idx_width(input int npins);
    return (npins > 1) ? $clog2(npins) : 1;
  endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

  // R1: the second stage follows the first by one cycle
  a_r1_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage2_q == $past(stage1_q)));

endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_trk_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_sync,
  input  logic             cfg_pol,
  input  logic             cfg_trig,
  input  logic             cfg_mask,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             grant,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic             svc_q,
  output logic             insv_q
);

  trig_e mode;
  logic  eff_lvl;
  logic  pend_q;
  logic  pend_d;
  logic  is_level;
  logic  rise;
  logic  eoi_hit;
  logic  want_svc;
  logic  svc_d;
  logic  insv_d;
  logic  insv_en;

  assign mode     = trig_e'(cfg_trig);
  assign is_level = (mode == TRIG_LEVEL);

  always_comb begin
    eff_lvl  = lvl_sync ^ cfg_pol;
    rise     = eff_lvl & ~pend_q;
    eoi_hit  = eoi_valid & (eoi_vec == cfg_vec);
    want_svc = is_level ? (eff_lvl & ~insv_q & ~grant) : rise;
    svc_d    = ~cfg_mask & ((svc_q & ~grant) | want_svc);
    insv_en  = (grant & is_level) | eoi_hit;
    insv_d   = grant & is_level;
    pend_d   = eff_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
      insv_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
      if (insv_en) begin
        insv_q <= insv_d;
      end
    end
  end

  // R5: a pin masked in one cycle holds no queued request in the next
  a_r5_mask_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |=> !svc_q);

  // R7: an accepted level delivery leaves the pin in service
  a_r7_level_sets_insv: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cfg_trig) |=> insv_q);

  // R8: a matching notice without a same-cycle level grant clears the flag
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && (eoi_vec == cfg_vec) && !(grant && cfg_trig)) |=> !insv_q);

  // R7: an edge-mode grant never raises the flag
  a_r7_edge_no_insv: assert property (@(posedge clk) disable iff (!rst_n)
    (!insv_q && !cfg_trig) |=> !insv_q);

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] req_vec,
  input  logic             ack,
  output logic             any_req,
  output logic [PIN_W-1:0] pick_idx,
  output logic [NPINS-1:0] gnt_vec
);

  always_comb begin
    pick_idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        pick_idx = PIN_W'(i);
      end
    end
  end

  assign any_req = |req_vec;

  for (genvar g = 0; g < NPINS; g++) begin : g_gnt
    assign gnt_vec[g] = any_req & ack & (pick_idx == PIN_W'(g));
  end

  // R6: at most one pin is granted at a time
  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));

  // R6: no lower-numbered pin is waiting when a pick is made
  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && req_vec[g]) |-> (int'(pick_idx) <= g));
  end

endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
  import irq_trk_pkg::*;
#(
  parameter  int NPINS = 8,
  parameter  int VEC_W = 8,
  localparam int PIN_W = pin_idx_width(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_raw,
  input  logic [NPINS-1:0]       cfg_pol,
  input  logic [NPINS-1:0]       cfg_trig,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  input  logic                   dlv_ack,
  output logic                   dlv_req,
  output logic [PIN_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vec,
  output logic [NPINS-1:0]       in_service
);

  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] svc_vec;
  logic [NPINS-1:0] live_req;
  logic [NPINS-1:0] gnt_vec;

  irq_sync2 #(.WIDTH(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (lvl_sync)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_cell #(.VEC_W(VEC_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_sync  (lvl_sync[g]),
      .cfg_pol   (cfg_pol[g]),
      .cfg_trig  (cfg_trig[g]),
      .cfg_mask  (cfg_mask[g]),
      .cfg_vec   (cfg_vec[g*VEC_W +: VEC_W]),
      .grant     (gnt_vec[g]),
      .eoi_valid (eoi_valid),
      .eoi_vec   (eoi_vec),
      .svc_q     (svc_vec[g]),
      .insv_q    (in_service[g])
    );
  end

  assign live_req = svc_vec & ~cfg_mask;

  irq_low_pick #(.NPINS(NPINS), .PIN_W(PIN_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vec  (live_req),
    .ack      (dlv_ack),
    .any_req  (dlv_req),
    .pick_idx (dlv_pin),
    .gnt_vec  (gnt_vec)
  );

  always_comb begin
    dlv_vec = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (dlv_pin == PIN_W'(i)) begin
        dlv_vec = cfg_vec[i*VEC_W +: VEC_W];
      end
    end
  end

  // R5: the named pin is never masked while a request is shown
  a_r5_no_masked_req: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> !cfg_mask[dlv_pin]);

  // R11: the request names a real pin
  a_r11_pin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> (int'(dlv_pin) < NPINS));

endmodule

// File: tb/sim_irq_pin_tracker.sv
`timescale 1ns/100ps
module sim_irq_pin_tracker;

  localparam int NP = 5;
  localparam int VW = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_raw, cfg_pol, cfg_trig, cfg_mask;
  logic [NP*VW-1:0] cfg_vec;
  logic          eoi_valid, dlv_ack;
  logic [VW-1:0] eoi_vec;
  logic          dlv_req;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vec;
  logic [NP-1:0] in_service;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [NP-1:0] m_s1, m_s2, m_prev, m_svc, m_ins;

  always #2.5 clk = ~clk;

  irq_pin_tracker #(.NPINS(NP), .VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_pol(cfg_pol),
    .cfg_trig(cfg_trig), .cfg_mask(cfg_mask), .cfg_vec(cfg_vec),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .dlv_ack(dlv_ack),
    .dlv_req(dlv_req), .dlv_pin(dlv_pin), .dlv_vec(dlv_vec),
    .in_service(in_service)
  );

  function automatic int vec_of(input int p);
    return int'(cfg_vec[p*VW +: VW]);
  endfunction

  function automatic int model_pin();
    for (int i = 0; i < NP; i++) if (m_svc[i] && !cfg_mask[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_svc <= '0; m_ins <= '0;
    end else begin
      int mp;
      mp = model_pin();
      for (int i = 0; i < NP; i++) begin
        bit eff, gr, want, hit;
        eff  = m_s2[i] ^ cfg_pol[i];
        gr   = (mp == i) && dlv_ack;
        want = cfg_trig[i] ? (eff && !m_ins[i] && !gr) : (eff && !m_prev[i]);
        hit  = eoi_valid && (vec_of(i) == int'(eoi_vec));
        m_svc[i] <= !cfg_mask[i] && ((m_svc[i] && !gr) || want);
        if (gr && cfg_trig[i]) m_ins[i] <= 1'b1;
        else if (hit) m_ins[i] <= 1'b0;
        m_prev[i] <= eff;
      end
      m_s2 <= m_s1;
      m_s1 <= pin_raw;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int mp;
      mp = model_pin();
      check("R6 R3 R4 model req", int'(dlv_req), int'(mp >= 0));
      if (mp >= 0) begin
        check("R6 model pin", int'(dlv_pin), mp);
        check("R11 model vec", int'(dlv_vec), vec_of(mp));
      end
      check("R7 R8 R9 model in_service", int'(in_service), int'(m_ins));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic eoi_pulse(input int v);
    eoi_vec = VW'(v); eoi_valid = 1'b1;
    step(1);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_raw = '0; cfg_pol = '0; cfg_trig = '0; cfg_mask = '1;
    cfg_vec = {4'd12, 4'd5, 4'd9, 4'd5, 4'd2};
    eoi_valid = 1'b0; eoi_vec = '0; dlv_ack = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R10 reset req", int'(dlv_req), 0);
    check("R10 reset in_service", int'(in_service), 0);
    cfg_mask = '0;
    step(3);

    // R1 latency, R11 vector, R3 single shot
    dlv_ack = 1'b0; pin_raw[2] = 1'b1;
    step(1); check("R1 after edge 1", int'(dlv_req), 0);
    step(1); check("R1 after edge 2", int'(dlv_req), 0);
    step(1); check("R1 after edge 3", int'(dlv_req), 1);
    check("R1 pin", int'(dlv_pin), 2);
    check("R11 vec", int'(dlv_vec), 9);
    dlv_ack = 1'b1;
    step(1); check("R3 accepted", int'(dlv_req), 0);
    step(5); check("R3 held high no repeat", int'(dlv_req), 0);
    pin_raw[2] = 1'b0;

    // R5 edge while masked lost, R2 active-low
    cfg_mask[1] = 1'b1; pin_raw[1] = 1'b1; cfg_pol[1] = 1'b1;
    step(4); cfg_mask[1] = 1'b0;
    step(4); check("R5 masked edge lost", int'(dlv_req), 0);
    pin_raw[1] = 1'b0;
    step(3); check("R2 active-low req", int'(dlv_req), 1);
    check("R2 active-low pin", int'(dlv_pin), 1);
    step(2);

    // R4 / R7 level pin
    cfg_trig[3] = 1'b1; dlv_ack = 1'b0; pin_raw[3] = 1'b1;
    step(3); check("R4 level req", int'(dlv_req), 1);
    check("R4 level pin", int'(dlv_pin), 3);
    check("R11 level vec", int'(dlv_vec), 5);
    dlv_ack = 1'b1;
    step(1); check("R7 in_service set", int'(in_service), 8);
    check("R4 no redelivery now", int'(dlv_req), 0);
    step(4); check("R4 no redelivery later", int'(dlv_req), 0);
    cfg_trig[1] = 1'b1; pin_raw[1] = 1'b0;
    step(5); check("R7 two pins in service", int'(in_service), 10);

    // R9 other vector, R8 shared vector
    eoi_pulse(9);
    step(2); check("R9 other vector ignored", int'(in_service), 10);
    eoi_pulse(5);
    check("R8 both cleared", int'(in_service), 0);
    step(1); check("R8 re-request", int'(dlv_req), 1);
    check("R6 lower pin first", int'(dlv_pin), 1);
    step(1); check("R6 next pin", int'(dlv_pin), 3);
    check("R7 pin1 back in service", int'(in_service), 2);
    step(1); check("R8 both back", int'(in_service), 10);
    check("R4 quiet", int'(dlv_req), 0);
    pin_raw[3] = 1'b0; pin_raw[1] = 1'b1; cfg_trig = '0;
    eoi_pulse(5);
    step(4); check("R3 edge mode no re-service", int'(dlv_req), 0);

    // R6 simultaneous
    dlv_ack = 1'b0; pin_raw[0] = 1'b1; pin_raw[4] = 1'b1;
    step(3); check("R6 pick 0", int'(dlv_pin), 0);
    check("R11 vec 0", int'(dlv_vec), 2);
    dlv_ack = 1'b1;
    step(1); check("R6 then 4 req", int'(dlv_req), 1);
    check("R6 then 4 pin", int'(dlv_pin), 4);
    check("R11 vec 4", int'(dlv_vec), 12);
    step(1); check("R6 drained", int'(dlv_req), 0);

    // R5 withdraw a queued request
    dlv_ack = 1'b0; pin_raw[2] = 1'b1;
    step(3); check("R5 queued", int'(dlv_req), 1);
    cfg_mask[2] = 1'b1;
    step(1); check("R5 masked hidden", int'(dlv_req), 0);
    cfg_mask[2] = 1'b0;
    step(2); check("R5 withdrawn", int'(dlv_req), 0);
    dlv_ack = 1'b1; pin_raw = '0;
    step(4);

    // random phase, compared with the model every cycle
    for (int c = 0; c < 3000; c++) begin
      pin_raw = NP'($urandom);
      if ($urandom_range(0, 15) == 0) cfg_mask = NP'($urandom) & NP'($urandom);
      if ($urandom_range(0, 15) == 0) cfg_trig = NP'($urandom);
      if ($urandom_range(0, 31) == 0) cfg_pol = NP'($urandom);
      dlv_ack = ($urandom_range(0, 2) != 0);
      eoi_valid = ($urandom_range(0, 5) == 0);
      eoi_vec = VW'(vec_of($urandom_range(0, NP - 1)));
      step(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule